// File: doc/BRIEF.md
# Processor Heartbeat Watchdog with Long and Short Timeouts

This block watches a heartbeat level that a processor toggles while its software is healthy. Every rising or falling transition of the heartbeat starts a new timeout window. If the level stays constant for a whole window, the block sends a one-cycle timeout request to the reset generator and drops a latched status output. Time is counted in ticks of a one-cycle timebase strobe, not in clock cycles. The heartbeat input is asynchronous and passes through a synchronizer inside the block.

There are two window lengths. The long window applies after every reset and every supply fault, because software often cannot service the watchdog right after it starts. The short window takes over only after the first heartbeat transition that follows reset release, and only while the period-select input asks for it. The window length is sampled each time the count restarts: on a heartbeat transition, on a timeout, or when reset releases. A change of the select input therefore takes effect at the next restart. While the supply-fault flag is set, the watchdog is parked. While the disable flag is set, no timeout can occur.

Top module: `wdt_dual_timeout`

## Requirements
- R1: A rising or a falling transition of the heartbeat clears the tick count and starts a new window.
- R2: The window is `SHORT_TICKS` or `LONG_TICKS` timebase ticks. `wd_bite` is a single-cycle pulse that is high in the clock cycle after the tick that completes the window.
- R3: The long window is used after reset and after a supply fault. The short window is used only after the first heartbeat transition seen once both have cleared, and only when `sel_short` is 1.
- R4: No ticks are counted while `rst_active` is 1, and no timeout request is issued then. Counting starts from zero when `rst_active` returns to 0.
- R5: While the heartbeat stays constant, a timeout request repeats once every window.
- R6: `wd_ok` goes to 0 in the same cycle as `wd_bite`. It stays 0 until a heartbeat transition sets it back to 1.
- R7: While `supply_fault` is 1, no ticks are counted, `wd_ok` is forced to 1, and heartbeat transitions are ignored: they do not select the short window.
- R8: While `hb_off` is 1, no timeout request is issued.
- R9: `sel_short` is sampled only at window restarts. A change in the middle of a window does not alter the length of the current window.
- R10: After `rst_n` reset, `wd_bite` is 0 and `wd_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe |
| hb_in | input | 1 | Asynchronous heartbeat level |
| hb_off | input | 1 | Watchdog disable (heartbeat floating) |
| supply_fault | input | 1 | Low supply or battery mode |
| rst_active | input | 1 | Reset generator currently holding reset |
| sel_short | input | 1 | 1 selects the short window once armed |
| wd_bite | output | 1 | Single-cycle timeout request |
| wd_ok | output | 1 | Latched watchdog status, 0 after a timeout |

## Verification
The assertions assume that `SHORT_TICKS` and `LONG_TICKS` are at least 2. They also assume the heartbeat settles within the synchronizer, so every edge the checker sees is one clean synchronized transition. The bench holds the heartbeat for at least four clocks between toggles. It changes all inputs on the falling clock edge and runs a reduced configuration of 4 and 10 ticks. With these short windows it can sweep every tick offset at which a transition can arrive inside a window.

// File: rtl/wdt_pkg.sv
// Shared types for the heartbeat watchdog.
package wdt_pkg;
    // Which window length a restart selected.
    typedef enum logic {
        PER_LONG  = 1'b0,
        PER_SHORT = 1'b1
    } period_t;
endpackage

// File: rtl/wdt_hb_sync.sv
// Heartbeat synchronizer and transition detector.
// Passes the asynchronous heartbeat through STAGES flops, then compares the
// last synchronized stage with one more flop. Output is high for one clock
// per transition. Assumes the heartbeat is stable for several clocks.
module wdt_hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_async,
    output logic hb_edge
);
    logic [STAGES:0] chain_q;

    // Shift the heartbeat through the synchronizer plus one history flop.
    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= hb_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Either direction of change counts as a transition.
    assign hb_edge = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/wdt_period_sel.sv
// Window length selection.
// Tracks whether a heartbeat transition has been seen since reset or fault
// cleared (armed). Latches the window length at every restart. While held,
// it forces the long window and disarms.
module wdt_period_sel
    import wdt_pkg::*;
#(
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 4096,
    parameter int CW          = $clog2(LONG_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          hb_edge,
    input  logic          restart,
    input  logic          sel_short,
    output logic [CW-1:0] term
);
    localparam logic [CW-1:0] T_SHORT = CW'(SHORT_TICKS);
    localparam logic [CW-1:0] T_LONG  = CW'(LONG_TICKS);

    logic    armed_q;
    period_t per_q;
    period_t per_next;

    // Short only if armed (now or by this edge) and the select asks for it.
    always_comb begin
        per_next = ((armed_q || hb_edge) && sel_short) ? PER_SHORT : PER_LONG;
    end

    // Arm on the first transition after hold; disarm while held.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (hold)    armed_q <= 1'b0;
        else if (hb_edge) armed_q <= 1'b1;
    end

    // Latch the window length at restarts only.
    always_ff @(posedge clk) begin
        if (!rst_n)       per_q <= PER_LONG;
        else if (hold)    per_q <= PER_LONG;
        else if (restart) per_q <= per_next;
    end

    assign term = (per_q == PER_SHORT) ? T_SHORT : T_LONG;
endmodule

// File: rtl/wdt_counter.sv
// Tick counter, timeout pulse and status latch.
// Counts timebase ticks from the last restart. When the count completes the
// window, it emits a registered single-cycle request and clears the status.
// Assumes term is at least 2.
module wdt_counter #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hold,
    input  logic          fault,
    input  logic          hb_off,
    input  logic          hb_edge,
    input  logic [CW-1:0] term,
    output logic          wrap,
    output logic [CW-1:0] cnt,
    output logic          bite,
    output logic          ok
);
    logic [CW-1:0] cnt_q;
    logic          bite_q;
    logic          ok_q;
    logic          parked;

    assign parked = hold || hb_off;

    // The window completes on the tick that takes the count to term.
    assign wrap = tick && !parked && !hb_edge && (cnt_q == term - CW'(1));

    // Advance on ticks; clear when parked, on a transition, or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (parked || hb_edge)   cnt_q <= '0;
        else if (wrap)                cnt_q <= '0;
        else if (tick)                cnt_q <= cnt_q + CW'(1);
    end

    // Register the timeout request as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) bite_q <= 1'b0;
        else        bite_q <= wrap;
    end

    // Status: forced high on fault, set by a transition, cleared by a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)       ok_q <= 1'b1;
        else if (fault)   ok_q <= 1'b1;
        else if (hb_edge) ok_q <= 1'b1;
        else if (wrap)    ok_q <= 1'b0;
    end

    assign cnt  = cnt_q;
    assign bite = bite_q;
    assign ok   = ok_q;
endmodule

// File: rtl/wdt_dual_timeout.sv
// Heartbeat watchdog with a long window after reset and a selectable short
// window once the heartbeat has been seen. Drops transitions during a supply
// fault. Assumes tick is a one-clock strobe and both windows are at least 2.
module wdt_dual_timeout #(
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hb_in,
    input  logic hb_off,
    input  logic supply_fault,
    input  logic rst_active,
    input  logic sel_short,
    output logic wd_bite,
    output logic wd_ok
);
    localparam int CW = $clog2(LONG_TICKS + 1);

    logic          edge_raw;
    logic          edge_q;
    logic          hold;
    logic          wrap_w;
    logic          restart_w;
    logic [CW-1:0] term_w;
    logic [CW-1:0] cnt_w;

    // Transitions are ignored during a supply fault.
    assign edge_q    = edge_raw && !supply_fault;
    assign hold      = rst_active || supply_fault;
    assign restart_w = edge_q || wrap_w;

    wdt_hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .hb_async (hb_in),
        .hb_edge  (edge_raw)
    );

    wdt_period_sel #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .CW          (CW)
    ) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .hb_edge   (edge_q),
        .restart   (restart_w),
        .sel_short (sel_short),
        .term      (term_w)
    );

    wdt_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .hold    (hold),
        .fault   (supply_fault),
        .hb_off  (hb_off),
        .hb_edge (edge_q),
        .term    (term_w),
        .wrap    (wrap_w),
        .cnt     (cnt_w),
        .bite    (wd_bite),
        .ok      (wd_ok)
    );
endmodule

// File: rtl/wdt_dual_timeout_chk.sv
// Property checker for the heartbeat watchdog, bound to the top module.
// Assumes both windows are at least 2 ticks.
module wdt_dual_timeout_chk #(
    parameter int CW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hb_off,
    input logic          supply_fault,
    input logic          rst_active,
    input logic          hb_edge,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] term,
    input logic          wd_bite,
    input logic          wd_ok
);
    AST_BITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_bite |=> !wd_bite); // R2

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < term); // R2

    AST_NO_BITE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> !wd_bite); // R4

    AST_NO_BITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        hb_off |=> !wd_bite); // R8

    AST_OK_LOW_WITH_BITE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_bite |-> !wd_ok); // R6

    AST_OK_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_ok) |-> ($past(hb_edge) || $past(supply_fault))); // R6

    AST_FAULT_OK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fault |=> (wd_ok && !wd_bite)); // R7
endmodule

bind wdt_dual_timeout wdt_dual_timeout_chk #(.CW($clog2(LONG_TICKS + 1))) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hb_off       (hb_off),
    .supply_fault (supply_fault),
    .rst_active   (rst_active),
    .hb_edge      (edge_q),
    .cnt          (cnt_w),
    .term         (term_w),
    .wd_bite      (wd_bite),
    .wd_ok        (wd_ok)
);

// File: tb/wdt_dual_timeout_test.sv
// Bench for the heartbeat watchdog with reduced windows of 4 and 10 ticks.
module wdt_dual_timeout_test;
    localparam int SHORT = 4;
    localparam int LONG  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic hb_in = 1'b0;
    logic hb_off = 1'b0;
    logic supply_fault = 1'b0;
    logic rst_active = 1'b0;
    logic sel_short = 1'b0;
    logic wd_bite;
    logic wd_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_dual_timeout #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) uut (
        .clk (clk), .rst_n (rst_n), .tick (tick), .hb_in (hb_in),
        .hb_off (hb_off), .supply_fault (supply_fault),
        .rst_active (rst_active), .sel_short (sel_short),
        .wd_bite (wd_bite), .wd_ok (wd_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Tick once per clock until a timeout request; returns tick count or -1.
    task automatic ticks_to_bite(input int lim, output int n);
        bit hit = 1'b0;
        n = 0;
        while (!hit && n < lim) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            n++;
            if (wd_bite) hit = 1'b1;
        end
        if (!hit) n = -1;
    endtask

    // Issue n ticks and count the timeout requests seen.
    task automatic tick_n(input int n, output int bites);
        bites = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (wd_bite) bites++;
        end
    endtask

    // Toggle the heartbeat and let it pass the synchronizer.
    task automatic toggle_hb();
        hb_in = ~hb_in;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 bite after reset", wd_bite, 0);
        check("R10 ok after reset", wd_ok, 1);

        // R4: held in reset, no counting and no timeout
        rst_active = 1'b1;
        tick_n(3 * LONG, b);
        check("R4 no bite while reset active", b, 0);
        rst_active = 1'b0;
        @(negedge clk);
        ticks_to_bite(4 * LONG, n);
        check("R4 R3 long window after release", n, LONG);
        check("R6 ok low after timeout", wd_ok, 0);

        // R5: repeated timeouts with a constant heartbeat
        for (int r = 0; r < 3; r++) begin
            ticks_to_bite(4 * LONG, n);
            check("R5 repeat period", n, LONG);
            check("R6 ok stays low", wd_ok, 0);
        end

        // R3 R1: short window after first transition, edge at every offset
        sel_short = 1'b1;
        toggle_hb();
        check("R6 ok set by transition", wd_ok, 1);
        for (int k = 0; k < SHORT; k++) begin
            tick_n(k, b);
            check("R1 no bite before transition", b, 0);
            toggle_hb();
            ticks_to_bite(4 * LONG, n);
            check("R1 transition restarts window", n, SHORT);
        end

        // R9: select change mid-window applies at the next restart
        toggle_hb();
        sel_short = 1'b0;
        ticks_to_bite(4 * LONG, n);
        check("R9 current window unchanged", n, SHORT);
        ticks_to_bite(4 * LONG, n);
        check("R9 next window long", n, LONG);

        // R8: disabled watchdog never times out
        hb_off = 1'b1;
        tick_n(3 * LONG, b);
        check("R8 no bite while disabled", b, 0);
        hb_off = 1'b0;
        @(negedge clk);

        // R7: fault forces ok high and drops transitions
        ticks_to_bite(4 * LONG, n);
        check("R7 prior timeout", wd_ok, 0);
        sel_short = 1'b1;
        supply_fault = 1'b1;
        @(negedge clk);
        check("R7 ok forced high", wd_ok, 1);
        toggle_hb();
        tick_n(3 * LONG, b);
        check("R7 no bite during fault", b, 0);
        supply_fault = 1'b0;
        @(negedge clk);
        ticks_to_bite(4 * LONG, n);
        check("R7 R3 transition in fault ignored, long window", n, LONG);

        // R3: reset disarms the short window even with select high
        toggle_hb();
        ticks_to_bite(4 * LONG, n);
        check("R3 short once armed", n, SHORT);
        rst_active = 1'b1;
        repeat (2) @(negedge clk);
        rst_active = 1'b0;
        @(negedge clk);
        ticks_to_bite(4 * LONG, n);
        check("R3 long after reset despite select", n, LONG);

        // R2: request lasts exactly one cycle
        @(negedge clk);
        check("R2 single-cycle request", wd_bite, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule